// File: doc/BRIEF.md
# Wake-up and Kickstart Power Controller

This block decides whether a system's main supply should be requested. It watches two wake sources: a one-cycle alarm-match pulse from a time-of-day comparator kept elsewhere, and an asynchronous, active-low kickstart pin. Each source owns a status flag that sets when the source fires. An active-low interrupt is requested while a flag is set and its enable bit is on, or while an external source reports a pending interrupt. Both the interrupt and the power request are open-drain lines. Each is modelled as a drive-enable: 1 pulls the line low, and 0 lets an outside pull-up hold it high.

Software reaches the block through a small register port with two addresses. On the status address, writing 0 to a flag bit clears that flag. On the control address sit the two enable bits, a retain-mode bit and a power-down command bit. The power request is kept by a three-state machine. `PWR_ON` drives the request and is the reset state. `PWR_OFF` releases it. `PWR_HOLD` is a powered-down state that keeps driving because retain mode is on. The transitions are:
- *shutdown*: `PWR_ON`→`PWR_OFF` on a power-down command with retain 0.
- *park*: `PWR_ON`→`PWR_HOLD` on a power-down command with retain 1.
- *wake*: `PWR_OFF` or `PWR_HOLD`→`PWR_ON` on any enabled event.
- *drop*: `PWR_HOLD`→`PWR_OFF` when retain is cleared.

A power-good input stands in for supply sensing. While it is low, the interrupt line is released, but flags and wake events keep working.

Top module: `wkpwr_ctrl`

## Requirements
- R1: After reset both flags, both enables and retain read 0, `pwr_oe` is 1 (state `PWR_ON`) and `irq_oe` follows only `ext_irq_pend`.
- R2: A one-cycle `alarm_match` sets the wake flag (status bit 0) at the same clock edge; it stays set until cleared.
- R3: A high-to-low change of `kick_n` sets the kick flag (status bit 1) at the third clock edge after the change; holding the pin low or a rising change never sets it again.
- R4: With `main_pwr_ok` high, `irq_oe` is 1 exactly when (wake flag and wake enable, control bit 0) or (kick flag and kick enable, control bit 1) or `ext_irq_pend`.
- R5: A write to the status address (reg_sel 0) with a flag's bit 0 clears that flag, a bit of 1 leaves it unchanged, and a flag set in the same cycle stays set.
- R6: A control write (reg_sel 1) with bit 3 set and bit 2 clear, without an enabled event in that cycle, takes `pwr_oe` to 0 from the next edge (shutdown).
- R7: A control write with bits 3 and 2 both set keeps `pwr_oe` at 1 (park); clearing bit 2 later releases `pwr_oe` two edges after the write (drop).
- R8: An event whose enable bit is set drives `pwr_oe` to 1 from the edge that sets its flag (wake), and wins over a power-down command in the same cycle; an event with its enable clear sets the flag but leaves `pwr_oe` released.
- R9: While `main_pwr_ok` is 0, `irq_oe` is 0, and flags and enabled wake events still act as in R2, R3 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_pwr_ok | input | 1 | Main supply present |
| alarm_match | input | 1 | One-cycle alarm-match pulse |
| kick_n | input | 1 | Asynchronous kickstart pin, active low |
| ext_irq_pend | input | 1 | Another interrupt source is pending |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 status, 1 control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (control bit 3 reads 0) |
| irq_oe | output | 1 | Interrupt line pull-low enable |
| pwr_oe | output | 1 | Power request line pull-low enable |

## Verification
The flags, enables and machine state are all observable at the ports: either through register reads or through `irq_oe` and `pwr_oe`. A flag that is wrongly set or not cleared shows up on the status read in the next cycle. With its enable on, the same fault also shows on `irq_oe` combinationally. A wrong machine state shows on `pwr_oe` in the cycle after the edge that should have moved it. The sweep drives every combination of flags, enables and the external pending input, under both power-good levels, and every retain, source and enable combination on the power path.

// File: rtl/wkpwr_pkg.sv
package wkpwr_pkg;
    typedef enum logic [1:0] {
        PWR_ON   = 2'd0,
        PWR_OFF  = 2'd1,
        PWR_HOLD = 2'd2
    } pwr_state_e;

    localparam int unsigned NUM_SRC  = 2;
    localparam int unsigned SRC_WAKE = 0;
    localparam int unsigned SRC_KICK = 1;

    localparam int unsigned CTL_WEN    = 0;
    localparam int unsigned CTL_KEN    = 1;
    localparam int unsigned CTL_RETAIN = 2;
    localparam int unsigned CTL_PDN    = 3;
endpackage

// File: rtl/wkpwr_edge_sync.sv
module wkpwr_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_n};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/wkpwr_flags.sv
module wkpwr_flags #(
    parameter int unsigned NSRC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic            clr_wr_i,
    input  logic [NSRC-1:0] clr_data_i,
    output logic [NSRC-1:0] flag_o
);
    for (genvar g = 0; g < NSRC; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_o[g] <= 1'b0;
            end else if (set_i[g]) begin
                flag_o[g] <= 1'b1;
            end else if (clr_wr_i && !clr_data_i[g]) begin
                flag_o[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/wkpwr_cfg.sv
module wkpwr_cfg
    import wkpwr_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [NUM_SRC-1:0] en_o,
    output logic              retain_o,
    output logic              pdn_req_o,
    output logic              pdn_retain_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_o     <= '0;
            retain_o <= 1'b0;
        end else if (wr_i) begin
            en_o[SRC_WAKE] <= wdata_i[CTL_WEN];
            en_o[SRC_KICK] <= wdata_i[CTL_KEN];
            retain_o       <= wdata_i[CTL_RETAIN];
        end
    end

    assign pdn_req_o    = wr_i & wdata_i[CTL_PDN];
    assign pdn_retain_o = wdata_i[CTL_RETAIN];
endmodule

// File: rtl/wkpwr_pwr_fsm.sv
module wkpwr_pwr_fsm
    import wkpwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wake_evt_i,
    input  logic       pdn_req_i,
    input  logic       pdn_retain_i,
    input  logic       retain_i,
    output logic       pwr_drive_o,
    output pwr_state_e state_o
);
    pwr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_ON: begin
                if (pdn_req_i && !wake_evt_i) begin
                    state_d = pdn_retain_i ? PWR_HOLD : PWR_OFF;
                end
            end
            PWR_OFF: begin
                if (wake_evt_i) state_d = PWR_ON;
            end
            PWR_HOLD: begin
                if (wake_evt_i)     state_d = PWR_ON;
                else if (!retain_i) state_d = PWR_OFF;
            end
            default: state_d = PWR_ON;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PWR_ON;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            PWR_ON:   pwr_drive_o = 1'b1;
            PWR_HOLD: pwr_drive_o = 1'b1;
            PWR_OFF:  pwr_drive_o = 1'b0;
            default:  pwr_drive_o = 1'b1;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/wkpwr_ctrl.sv
module wkpwr_ctrl
    import wkpwr_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              main_pwr_ok,
    input  logic              alarm_match,
    input  logic              kick_n,
    input  logic              ext_irq_pend,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_oe,
    output logic              pwr_oe
);
    localparam int unsigned PAD_W = DATA_W - NUM_SRC;

    logic               kick_fall;
    logic [NUM_SRC-1:0] src_set;
    logic [NUM_SRC-1:0] flag_q;
    logic [NUM_SRC-1:0] en_q;
    logic               retain_q;
    logic               pdn_req;
    logic               pdn_retain;
    logic               wake_evt;
    pwr_state_e         pwr_state;

    wkpwr_edge_sync #(.STAGES(SYNC_STAGES)) u_kick (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_n  (kick_n),
        .fall_o (kick_fall)
    );

    assign src_set[SRC_WAKE] = alarm_match;
    assign src_set[SRC_KICK] = kick_fall;

    wkpwr_flags #(.NSRC(NUM_SRC)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (src_set),
        .clr_wr_i   (reg_wr && !reg_sel),
        .clr_data_i (reg_wdata[NUM_SRC-1:0]),
        .flag_o     (flag_q)
    );

    wkpwr_cfg #(.DATA_W(DATA_W)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (reg_wr && reg_sel),
        .wdata_i      (reg_wdata),
        .en_o         (en_q),
        .retain_o     (retain_q),
        .pdn_req_o    (pdn_req),
        .pdn_retain_o (pdn_retain)
    );

    assign wake_evt = |(src_set & en_q);

    wkpwr_pwr_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .wake_evt_i   (wake_evt),
        .pdn_req_i    (pdn_req),
        .pdn_retain_i (pdn_retain),
        .retain_i     (retain_q),
        .pwr_drive_o  (pwr_oe),
        .state_o      (pwr_state)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_sel) begin
            reg_rdata[CTL_WEN]    = en_q[SRC_WAKE];
            reg_rdata[CTL_KEN]    = en_q[SRC_KICK];
            reg_rdata[CTL_RETAIN] = retain_q;
        end else begin
            reg_rdata = {{PAD_W{1'b0}}, flag_q};
        end
    end

    assign irq_oe = main_pwr_ok & ((|(flag_q & en_q)) | ext_irq_pend);
endmodule

// File: rtl/wkpwr_ctrl_chk.sv
module wkpwr_ctrl_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              main_pwr_ok,
    input logic              alarm_match,
    input logic              ext_irq_pend,
    input logic              reg_wr,
    input logic              reg_sel,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [1:0]        flags,
    input logic [1:0]        en,
    input logic              kick_fall,
    input logic              irq_oe,
    input logic              pwr_oe
);
    logic any_evt;
    assign any_evt = (alarm_match && en[0]) || (kick_fall && en[1]);

    always @(negedge clk) begin
        if (rst_n === 1'b0) begin
            a_r1_reset_state: assert (pwr_oe && flags == 2'b00 && en == 2'b00);
        end
    end

    a_r2_wake_sets: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_match |=> flags[0]);

    a_r3_kick_once: assert property (@(posedge clk) disable iff (!rst_n)
        kick_fall |=> !kick_fall);

    a_r4_ext_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (main_pwr_ok && ext_irq_pend) |-> irq_oe);

    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel && !reg_wdata[0] && !alarm_match) |=> !flags[0]);

    a_r6_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel && reg_wdata[3] && !reg_wdata[2] && !any_evt) |=> !pwr_oe);

    a_r7_park: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel && reg_wdata[3] && reg_wdata[2] && pwr_oe) |=> pwr_oe);

    a_r8_wake: assert property (@(posedge clk) disable iff (!rst_n)
        any_evt |=> pwr_oe);

    a_r9_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
        !main_pwr_ok |-> !irq_oe);
endmodule

bind wkpwr_ctrl wkpwr_ctrl_chk #(.DATA_W(DATA_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .main_pwr_ok  (main_pwr_ok),
    .alarm_match  (alarm_match),
    .ext_irq_pend (ext_irq_pend),
    .reg_wr       (reg_wr),
    .reg_sel      (reg_sel),
    .reg_wdata    (reg_wdata),
    .flags        (flag_q),
    .en           (en_q),
    .kick_fall    (kick_fall),
    .irq_oe       (irq_oe),
    .pwr_oe       (pwr_oe)
);

// File: tb/wkpwr_ctrl_tb_top.sv
`timescale 1ns/1ps
module wkpwr_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       main_pwr_ok = 1'b1;
    logic       alarm_match = 1'b0;
    logic       kick_n = 1'b1;
    logic       ext_irq_pend = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_oe;
    logic       pwr_oe;
    logic       irq_line;
    logic       pwr_line;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wkpwr_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .main_pwr_ok  (main_pwr_ok),
        .alarm_match  (alarm_match),
        .kick_n       (kick_n),
        .ext_irq_pend (ext_irq_pend),
        .reg_wr       (reg_wr),
        .reg_sel      (reg_sel),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .irq_oe       (irq_oe),
        .pwr_oe       (pwr_oe)
    );

    // pull-up resolution of the open-drain lines
    assign irq_line = irq_oe ? 1'b0 : 1'b1;
    assign pwr_line = pwr_oe ? 1'b0 : 1'b1;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic rd(input logic sel, output logic [7:0] d);
        reg_sel = sel;
        #1;
        d = reg_rdata;
    endtask

    task automatic alarm_pulse();
        alarm_match = 1'b1;
        @(negedge clk);
        alarm_match = 1'b0;
    endtask

    task automatic kick_pulse();
        kick_n = 1'b0;
        repeat (4) @(negedge clk);
        kick_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        logic [7:0] d;
        logic exp;
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(1'b0, d); chk("R1 status", d, 8'h00);
        rd(1'b1, d); chk("R1 control", d, 8'h00);
        chk("R1 pwr", {7'd0, pwr_oe}, 8'h01);
        chk("R1 irq", {7'd0, irq_oe}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pwr line low", {7'd0, pwr_line}, 8'h00);

        // R2 R3 R4 R9 sweep over flags, enables, external pending
        for (int c = 0; c < 32; c++) begin
            logic wf, kf, we, ke, ex;
            {wf, kf, we, ke, ex} = c[4:0];
            wr(1'b0, 8'h00);
            wr(1'b1, {6'd0, ke, we});
            if (wf) alarm_pulse();
            if (kf) kick_pulse();
            rd(1'b0, d); chk("R2/R3 flags", d, {6'd0, kf, wf});
            ext_irq_pend = ex;
            #1;
            exp = (wf & we) | (kf & ke) | ex;
            chk("R4 irq", {7'd0, irq_oe}, {7'd0, exp});
            chk("R4 irq line", {7'd0, irq_line}, {7'd0, ~exp});
            main_pwr_ok = 1'b0;
            #1;
            chk("R9 irq off", {7'd0, irq_oe}, 8'h00);
            main_pwr_ok = 1'b1;
            ext_irq_pend = 1'b0;
            @(negedge clk);
        end

        // R3 held low and rising change do not set again
        wr(1'b0, 8'h00);
        kick_n = 1'b0;
        repeat (4) @(negedge clk);
        wr(1'b0, 8'hFD);
        repeat (4) @(negedge clk);
        rd(1'b0, d); chk("R3 held low", d, 8'h00);
        kick_n = 1'b1;
        repeat (4) @(negedge clk);
        rd(1'b0, d); chk("R3 rising", d, 8'h00);

        // R5 selective clear and set-wins
        alarm_pulse(); kick_pulse();
        wr(1'b0, 8'h01);
        rd(1'b0, d); chk("R5 selective clear", d, 8'h01);
        alarm_match = 1'b1;
        wr(1'b0, 8'h00);
        alarm_match = 1'b0;
        rd(1'b0, d); chk("R5 set wins", d, 8'h01);
        wr(1'b0, 8'h00);
        rd(1'b0, d); chk("R5 clear", d, 8'h00);

        // R6 R7 R8 sweep over retain, source, enable
        for (int c = 0; c < 8; c++) begin
            logic rt, src, en;
            logic [7:0] enb;
            {rt, src, en} = c[2:0];
            enb = {6'd0, (src & en), (~src & en)};
            wr(1'b0, 8'h00);
            wr(1'b1, enb | {5'd0, rt, 2'd0});
            wr(1'b1, enb | {5'd0, rt, 2'd0} | 8'h08);
            chk(rt ? "R7 park" : "R6 shutdown", {7'd0, pwr_oe}, {7'd0, rt});
            if (src) kick_pulse(); else alarm_pulse();
            chk("R8 event", {7'd0, pwr_oe}, {7'd0, rt | en});
            rd(1'b0, d); chk("R8 flag", d, src ? 8'h02 : 8'h01);
            wr(1'b1, 8'h01);
            @(negedge clk);
            alarm_pulse();
            chk("R8 restore", {7'd0, pwr_oe}, 8'h01);
        end

        // R7 drop from hold when retain cleared
        wr(1'b1, 8'h0C);
        chk("R7 hold", {7'd0, pwr_oe}, 8'h01);
        wr(1'b1, 8'h00);
        chk("R7 hold one edge", {7'd0, pwr_oe}, 8'h01);
        @(negedge clk);
        chk("R7 drop", {7'd0, pwr_oe}, 8'h00);

        // R8 event beats power-down in same cycle
        wr(1'b1, 8'h01);
        @(negedge clk);
        alarm_match = 1'b1;
        wr(1'b1, 8'h09);
        alarm_match = 1'b0;
        chk("R8 event beats pdn", {7'd0, pwr_oe}, 8'h01);

        // R9 monitoring continues without main power
        main_pwr_ok = 1'b0;
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h0A);
        chk("R9 off", {7'd0, pwr_oe}, 8'h00);
        kick_pulse();
        chk("R9 kick wakes", {7'd0, pwr_oe}, 8'h01);
        rd(1'b0, d); chk("R9 flag", d, 8'h02);
        chk("R9 irq released", {7'd0, irq_oe}, 8'h00);
        main_pwr_ok = 1'b1;
        #1;
        chk("R9 irq back", {7'd0, irq_oe}, 8'h01);

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule